// File: doc/BRIEF.md
# Two-Stage Watchdog Escalator

The block watches one bit of a free-running 64-bit time base and treats every 0-to-1 transition of that bit as a watchdog expiry. Software picks the bit, and so the interval, from four taps with a 2-bit select. The first expiry that finds the block idle raises a pending bit, which drives the interrupt when the interrupt enable is on. If another expiry arrives while the pending bit is still set, the block escalates. It sets a second status bit and, unless software chose "no reset", raises a reset request together with the reset type that software picked.

Software services the watchdog by pulsing the clear strobe. The strobe drops both status bits. A strobe in the same cycle as an expiry counts as service, so that expiry has no effect. Once a reset request is out, it stays high until the block itself is reset. The reported type is frozen at the value that caused the request, so a late write cannot retarget the reset. The logic that carries out the reset lies outside this block.

Top module: `wdog_escalator`

## Requirements
- R1: After the synchronous reset, `irq`, `status`, `rst_req` and `rst_type` are all zero. A selected tap that is already 1 in the first cycle after reset does not count as an expiry.
- R2: `period_sel` value k selects time-base bit TAP_LO + k*TAP_STEP, which is bit 8, 12, 16 or 20 with the defaults. Transitions on any other bit cause no expiry.
- R3: An expiry is the selected tap reading 1 in a cycle after it read 0 in the previous cycle. An expiry with `status[0]` (pending) clear and no clear strobe sets `status[0]` at the next clock edge.
- R4: `irq` equals `status[0]` AND `irq_en`, and follows `irq_en` in the same cycle.
- R5: An expiry while `status[0]` is set and no clear strobe is present sets `status[1]` (escalated). It also sets `rst_req` when the held reset type is nonzero.
- R6: The reset type encoding is 00 = none, 01 = core, 10 = chip, 11 = system. With type 00 the second expiry sets `status[1]` but no request, and `irq` stays asserted.
- R7: Once `rst_req` is 1 it stays 1 until the block reset. The clear strobe does not lower it.
- R8: `rst_type` shows the `rst_kind` input as registered one cycle earlier. From the edge on which `rst_req` rises, `rst_type` holds the value that caused the request until the block reset.
- R9: A clear strobe in the same cycle as an expiry leaves both status bits clear at the next edge and raises no request.
- R10: A clear strobe without an expiry clears `status[0]` and `status[1]` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbase | input | 64 | Shared time-base value |
| period_sel | input | 2 | Chooses one of four time-base taps |
| rst_kind | input | 2 | Reset type to request on escalation |
| irq_en | input | 1 | Interrupt enable |
| wd_clear | input | 1 | Software service strobe, clears status |
| irq | output | 1 | Watchdog interrupt |
| status | output | 2 | bit0 pending, bit1 escalated |
| rst_req | output | 1 | Sticky reset request |
| rst_type | output | 2 | Held reset type |

## Verification
Directed cases toggle the selected tap and then a non-selected tap. This shows whether the tap mux decodes the select correctly and whether the edge detector ignores a tap that is already high after reset. Pairs of expiries are run with each reset type, with and without a clear in between and with a clear in the same cycle as the expiry. These separate first-stage behaviour from escalation, type 00 from a real reset, and correct clear-wins priority from a wrong one. A random phase then advances the time base in uneven steps and mixes in select changes, type writes, clears and resets. It compares every output in every cycle against a reference model in the bench, which exercises type writes during and after a request.

// File: rtl/wdx_pkg.sv
package wdx_pkg;

    typedef enum logic [1:0] {
        RK_NONE = 2'b00,
        RK_CORE = 2'b01,
        RK_CHIP = 2'b10,
        RK_SYS  = 2'b11
    } rst_kind_e;

    typedef struct packed {
        logic esc;
        logic pend;
    } wd_stat_t;

    localparam int NUM_TAPS = 4;

    function automatic int tap_pos(input int lo, input int step, input int k);
        return lo + step * k;
    endfunction

endpackage

// File: rtl/wdx_tap_edge.sv
module wdx_tap_edge #(
    parameter int TB_W     = 64,
    parameter int TAP_LO   = 8,
    parameter int TAP_STEP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TB_W-1:0] tbase,
    input  logic [1:0]      sel,
    output logic            expire
);
    import wdx_pkg::*;

    logic [NUM_TAPS-1:0] taps;
    logic                tap_now;
    logic                tap_q;

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        localparam int POS = tap_pos(TAP_LO, TAP_STEP, k);
        assign taps[k] = tbase[POS];
    end

    assign tap_now = taps[sel];

    // Reset to 1 so a tap already high right after reset is not an edge.
    always_ff @(posedge clk) begin
        if (rst) tap_q <= 1'b1;
        else     tap_q <= tap_now;
    end

    assign expire = tap_now & ~tap_q;

endmodule

// File: rtl/wdx_kind_hold.sv
module wdx_kind_hold (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          kind_in,
    input  logic                freeze,
    output wdx_pkg::rst_kind_e  kind_q
);
    import wdx_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)          kind_q <= RK_NONE;
        else if (!freeze) kind_q <= rst_kind_e'(kind_in);
    end

endmodule

// File: rtl/wdx_escalate.sv
module wdx_escalate (
    input  logic                clk,
    input  logic                rst,
    input  logic                expire,
    input  logic                clear,
    input  wdx_pkg::rst_kind_e  kind,
    output wdx_pkg::wd_stat_t   stat,
    output logic                req,
    output logic                fire
);
    import wdx_pkg::*;

    wd_stat_t stat_n;
    logic     req_n;

    assign fire = expire & ~clear & stat.pend & (kind != RK_NONE);

    always_comb begin
        stat_n = stat;
        req_n  = req | fire;
        if (clear) begin
            stat_n = '0;
        end else if (expire) begin
            if (!stat.pend) stat_n.pend = 1'b1;
            else            stat_n.esc  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            req  <= 1'b0;
        end else begin
            stat <= stat_n;
            req  <= req_n;
        end
    end

endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator #(
    parameter int TB_W     = 64,
    parameter int TAP_LO   = 8,
    parameter int TAP_STEP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TB_W-1:0] tbase,
    input  logic [1:0]      period_sel,
    input  logic [1:0]      rst_kind,
    input  logic            irq_en,
    input  logic            wd_clear,
    output logic            irq,
    output logic [1:0]      status,
    output logic            rst_req,
    output logic [1:0]      rst_type
);
    import wdx_pkg::*;

    logic      expire;
    logic      fire;
    logic      req_q;
    rst_kind_e kind_q;
    wd_stat_t  stat_q;

    wdx_tap_edge #(
        .TB_W    (TB_W),
        .TAP_LO  (TAP_LO),
        .TAP_STEP(TAP_STEP)
    ) u_tap (
        .clk   (clk),
        .rst   (rst),
        .tbase (tbase),
        .sel   (period_sel),
        .expire(expire)
    );

    wdx_kind_hold u_kind (
        .clk    (clk),
        .rst    (rst),
        .kind_in(rst_kind),
        .freeze (req_q | fire),
        .kind_q (kind_q)
    );

    wdx_escalate u_esc (
        .clk   (clk),
        .rst   (rst),
        .expire(expire),
        .clear (wd_clear),
        .kind  (kind_q),
        .stat  (stat_q),
        .req   (req_q),
        .fire  (fire)
    );

    assign status   = stat_q;
    assign irq      = stat_q.pend & irq_en;
    assign rst_req  = req_q;
    assign rst_type = kind_q;

endmodule

// File: rtl/wdog_escalator_chk.sv
module wdog_escalator_chk (
    input logic       clk,
    input logic       rst,
    input logic       wd_clear,
    input logic [1:0] status,
    input logic       rst_req,
    input logic [1:0] rst_type
);
    // R7
    req_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req);

    // R8
    type_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> $stable(rst_type));

    // R6
    type_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (rst_type != 2'b00));

    // R5
    req_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(status[0]));

    // R5
    esc_implies_pend_chk: assert property (@(posedge clk) disable iff (rst)
        status[1] |-> status[0]);

    // R10
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        wd_clear |=> (status == 2'b00));

endmodule

bind wdog_escalator wdog_escalator_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wd_clear(wd_clear),
    .status  (status),
    .rst_req (rst_req),
    .rst_type(rst_type)
);

// File: tb/sim_wdog_escalator.sv
`timescale 1ns/1ps
module sim_wdog_escalator;
    localparam int TAP_LO   = 8;
    localparam int TAP_STEP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] tbase = '0;
    logic [1:0]  period_sel = 2'd0;
    logic [1:0]  rst_kind = 2'd0;
    logic        irq_en = 1'b0;
    logic        wd_clear = 1'b0;
    logic        irq;
    logic [1:0]  status;
    logic        rst_req;
    logic [1:0]  rst_type;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    wdog_escalator #(.TB_W(64), .TAP_LO(TAP_LO), .TAP_STEP(TAP_STEP)) u0 (
        .clk(clk), .rst(rst), .tbase(tbase), .period_sel(period_sel),
        .rst_kind(rst_kind), .irq_en(irq_en), .wd_clear(wd_clear),
        .irq(irq), .status(status), .rst_req(rst_req), .rst_type(rst_type)
    );

    // Reference model built from the requirements
    logic       m_tapq = 1'b1;
    logic       m_pend = 1'b0;
    logic       m_esc  = 1'b0;
    logic       m_req  = 1'b0;
    logic [1:0] m_kind = 2'd0;

    function automatic logic tap_of(input logic [63:0] t, input logic [1:0] s);
        return t[TAP_LO + TAP_STEP * int'(s)];
    endfunction

    always @(posedge clk) begin
        logic tap, ex, fire;
        if (rst) begin
            m_tapq = 1'b1; m_pend = 1'b0; m_esc = 1'b0;
            m_req = 1'b0; m_kind = 2'd0;
        end else begin
            tap  = tap_of(tbase, period_sel);
            ex   = tap & ~m_tapq;
            m_tapq = tap;
            fire = ex & ~wd_clear & m_pend & (m_kind != 2'd0);
            if (!(m_req || fire)) m_kind = rst_kind;
            if (fire) m_req = 1'b1;
            if (wd_clear) begin
                m_pend = 1'b0; m_esc = 1'b0;
            end else if (ex) begin
                if (!m_pend) m_pend = 1'b1;
                else         m_esc  = 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Continuous comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 irq",    {7'd0, irq},       {7'd0, m_pend & irq_en});
            chk("R3 pend",   {7'd0, status[0]}, {7'd0, m_pend});
            chk("R5 esc",    {7'd0, status[1]}, {7'd0, m_esc});
            chk("R7 req",    {7'd0, rst_req},   {7'd0, m_req});
            chk("R8 type",   {6'd0, rst_type},  {6'd0, m_kind});
        end
    end

    // One cycle of stimulus; returns just after the edge that registered it
    task automatic step(input logic [63:0] t, input logic c);
        @(posedge clk); #1;
        tbase = t; wd_clear = c;
        @(posedge clk); #1;
        wd_clear = 1'b0;
    endtask

    task automatic do_reset(input logic [63:0] t);
        @(posedge clk); #1;
        rst = 1'b1; tbase = t; wd_clear = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    localparam logic [63:0] B8  = 64'h100;
    localparam logic [63:0] B12 = 64'h1000;

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: reset with tap already high
        do_reset(B8);
        chk("R1 status", {6'd0, status}, 8'd0);
        chk("R1 req",    {7'd0, rst_req}, 8'd0);
        chk("R1 type",   {6'd0, rst_type}, 8'd0);
        step(B8, 1'b0);
        chk("R1 no edge after reset", {6'd0, status}, 8'd0);

        // R3/R4: first expiry
        rst_kind = 2'b01; irq_en = 1'b1;
        step(64'd0, 1'b0);
        step(B8, 1'b0);
        chk("R3 first expiry", {6'd0, status}, 8'h01);
        chk("R4 irq on",       {7'd0, irq}, 8'd1);
        irq_en = 1'b0; #0.5;
        chk("R4 irq masked",   {7'd0, irq}, 8'd0);
        irq_en = 1'b1;

        // R5/R6: second expiry with core reset type
        step(64'd0, 1'b0);
        step(B8, 1'b0);
        chk("R5 escalated", {6'd0, status}, 8'h03);
        chk("R5 req",       {7'd0, rst_req}, 8'd1);
        chk("R6 type core", {6'd0, rst_type}, 8'h01);

        // R8: type frozen; R7/R10: clear drops status, not req
        rst_kind = 2'b10;
        step(64'd0, 1'b0);
        step(64'd0, 1'b1);
        chk("R8 type frozen", {6'd0, rst_type}, 8'h01);
        chk("R10 clear",      {6'd0, status}, 8'h00);
        chk("R7 req held",    {7'd0, rst_req}, 8'd1);

        // R6: type 00 gives no request
        rst_kind = 2'b00;
        do_reset(64'd0);
        step(64'd0, 1'b0);
        step(B8, 1'b0);
        step(64'd0, 1'b0);
        step(B8, 1'b0);
        chk("R6 none esc",  {6'd0, status}, 8'h03);
        chk("R6 none req",  {7'd0, rst_req}, 8'd0);
        chk("R6 none irq",  {7'd0, irq}, 8'd1);

        // R9: clear coincident with expiry
        rst_kind = 2'b11;
        step(64'd0, 1'b1);
        step(B8, 1'b0);
        chk("R9 setup pend", {6'd0, status}, 8'h01);
        step(64'd0, 1'b0);
        step(B8, 1'b1);
        chk("R9 serviced", {6'd0, status}, 8'h00);
        chk("R9 no req",   {7'd0, rst_req}, 8'd0);

        // R2: non-selected tap ignored, selected tap counts
        period_sel = 2'd1;
        step(64'd0, 1'b0);
        step(64'd0, 1'b0);
        step(B8, 1'b0);
        chk("R2 other bit ignored", {6'd0, status}, 8'h00);
        step(B12, 1'b0);
        chk("R2 selected bit", {6'd0, status}, 8'h01);
        period_sel = 2'd3;
        step(64'd0, 1'b1);
        step(64'h10_0000, 1'b0);
        chk("R2 top tap", {6'd0, status}, 8'h01);

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            @(posedge clk); #1;
            tbase    = tbase + 64'($urandom_range(0, 400));
            wd_clear = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 63) == 0) period_sel = 2'($urandom_range(0, 1));
            if ($urandom_range(0, 15) == 0) rst_kind = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 31) == 0) irq_en = ~irq_en;
            rst = ($urandom_range(0, 499) == 0);
        end
        @(posedge clk); #1;
        rst = 1'b0; wd_clear = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule